// File: doc/BRIEF.md
# Uncorrectable Fault Address Latch

This block records where uncorrectable faults happened. Each fault source (by default two: an interconnect and a RAM) drives a one-cycle valid strobe with the full fault address. The first fault on a source is captured into that source's address register, and the source's sticky status bit is set. From then on the register is frozen. Further faults on that source are dropped without trace until software clears the status bit.

Each time a status bit goes from clear to set, the block raises a one-cycle event toward the safety monitor. Events from all sources are merged into one output. Software reads the status word and the frozen addresses through a simple register port. It clears status bits by writing ones to the status word, and such a write takes effect only when the access is flagged as privileged.

The fault inputs carry no ready signal and cannot be back-pressured. A strobe is always consumed in its cycle: it is either captured or discarded. The register port is plain and has no handshake. Reads are combinational, and writes take effect at the next clock edge.

Top module: `uerr_addr_latch`

## Requirements
- R1: After reset, every status bit is 0, every address register reads 0, and `sm_event` is 0.
- R2: A strobe on source i whose status bit is clear captures all 32 address bits unmodified. It also sets status bit i. The status word is at register offset 0, with bit i for source i. The address of source i is at offset 1+i.
- R3: While status bit i is set, a strobe on source i changes neither the address register nor the status, and it raises no event.
- R4: `sm_event` is high for exactly one cycle. That cycle follows the clock edge at which a status bit newly set.
- R5: A privileged write to offset 0 clears exactly the status bits written as 1. Bits written as 0 keep their value, and the address registers keep their frozen value.
- R6: A write with `csr_priv` low has no effect on any status bit or address.
- R7: A strobe in the same cycle as a privileged clear of the same source is captured. The status bit stays set, the new address is stored and an event fires.
- R8: Sources are independent. Strobes on several sources in one cycle capture each source whose bit was clear, and together they raise a single one-cycle event.
- R9: Reads return the same value whatever the state of `csr_priv`. Writes to the address offsets are ignored.
- R10: After a clear, the next strobe on that source is captured afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| flt_valid | input | NUM_SRC | Per-source uncorrectable fault strobe |
| flt_addr | input | NUM_SRC*ADDR_W | Per-source fault address; source i uses bits [i*ADDR_W +: ADDR_W] |
| sm_event | output | 1 | One-cycle uncorrectable event to the safety monitor |
| csr_addr | input | CSR_AW | Register offset: 0 for status, 1+i for the address of source i |
| csr_wr | input | 1 | Write strobe |
| csr_priv | input | 1 | Access is privileged |
| csr_wdata | input | ADDR_W | Write data; ones in bits [NUM_SRC-1:0] clear status bits |
| csr_rdata | output | ADDR_W | Combinational read data |

## Verification
The bench builds the block with the defaults NUM_SRC=2 and ADDR_W=32. With two sources it can test a clear and a capture on one source while the other source stays frozen, and it can drive strobes on both sources in one cycle to check that they merge into one event. The full 32-bit width lets the bench use addresses with the top bit set, the bottom bit set, or all bits set, so any truncation or alignment of the captured address would show.

// File: rtl/ual_pkg.sv
package ual_pkg;
  // Register offsets; the address window follows the status word.
  localparam int unsigned OFS_STATUS    = 0;
  localparam int unsigned OFS_ADDR_BASE = 1;
endpackage

// File: rtl/ual_slot.sv
module ual_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              clr,
  output logic              set_now,
  output logic              held,
  output logic [ADDR_W-1:0] addr_q
);
  // A clear frees the slot in the same cycle, so a coincident fault is taken.
  always_comb set_now = flt_valid && (!held || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      addr_q <= '0;
    end else if (set_now) begin
      held   <= 1'b1;
      addr_q <= flt_addr;
    end else if (clr) begin
      held   <= 1'b0;
    end
  end
endmodule

// File: rtl/ual_csr_mux.sv
module ual_csr_mux #(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 32,
  parameter int CSR_AW  = 2
) (
  input  logic [CSR_AW-1:0]         csr_addr,
  input  logic [NUM_SRC-1:0]        status,
  input  logic [NUM_SRC*ADDR_W-1:0] addr_flat,
  output logic [ADDR_W-1:0]         rdata
);
  import ual_pkg::*;

  always_comb begin
    rdata = '0;
    if (int'(csr_addr) == OFS_STATUS) rdata[NUM_SRC-1:0] = status;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(csr_addr) == OFS_ADDR_BASE + i) rdata = addr_flat[i*ADDR_W +: ADDR_W];
    end
  end
endmodule

// File: rtl/uerr_addr_latch.sv
module uerr_addr_latch #(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 32,
  localparam int CSR_AW = (NUM_SRC + 1 > 2) ? $clog2(NUM_SRC + 1) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        flt_valid,
  input  logic [NUM_SRC*ADDR_W-1:0] flt_addr,
  output logic                      sm_event,
  input  logic [CSR_AW-1:0]         csr_addr,
  input  logic                      csr_wr,
  input  logic                      csr_priv,
  input  logic [ADDR_W-1:0]         csr_wdata,
  output logic [ADDR_W-1:0]         csr_rdata
);
  import ual_pkg::*;

  logic                      stat_wr;
  logic [NUM_SRC-1:0]        clr_vec;
  logic [NUM_SRC-1:0]        set_vec;
  logic [NUM_SRC-1:0]        status_vec;
  logic [NUM_SRC*ADDR_W-1:0] addr_flat;

  // Only a privileged write to the status word can clear anything.
  assign stat_wr = csr_wr && csr_priv && (int'(csr_addr) == OFS_STATUS);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    assign clr_vec[g] = stat_wr && csr_wdata[g];

    ual_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flt_valid(flt_valid[g]),
      .flt_addr (flt_addr[g*ADDR_W +: ADDR_W]),
      .clr      (clr_vec[g]),
      .set_now  (set_vec[g]),
      .held     (status_vec[g]),
      .addr_q   (addr_flat[g*ADDR_W +: ADDR_W])
    );
  end

  // One merged pulse for all sources, aligned with the status update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sm_event <= 1'b0;
    else        sm_event <= |set_vec;
  end

  ual_csr_mux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CSR_AW(CSR_AW)) u_mux (
    .csr_addr (csr_addr),
    .status   (status_vec),
    .addr_flat(addr_flat),
    .rdata    (csr_rdata)
  );
endmodule

// File: rtl/ual_checker.sv
module ual_checker #(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        flt_valid,
  input logic                      csr_wr,
  input logic                      csr_priv,
  input logic                      sm_event,
  input logic [NUM_SRC-1:0]        status_q,
  input logic [NUM_SRC*ADDR_W-1:0] addr_q
);
  // R4: an event needs a fault strobe in the previous cycle.
  assert_event_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sm_event |-> $past(|flt_valid));

  // R4: an event needs a status bit that is set now.
  assert_event_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sm_event |-> (|status_q));

  // R6: without a privileged write no status bit can fall.
  assert_no_unpriv_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && csr_priv) |=> ((status_q & $past(status_q)) == $past(status_q)));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // R2: a strobe on a clear source sets its status bit.
    assert_capture_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid[g] && !status_q[g]) |=> status_q[g]);

    // R3: a set source without a privileged write keeps its address.
    assert_frozen_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[g] && !(csr_wr && csr_priv)) |=> $stable(addr_q[g*ADDR_W +: ADDR_W]));

    // R10: an address only changes alongside a strobe.
    assert_addr_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid[g] |=> $stable(addr_q[g*ADDR_W +: ADDR_W]));
  end
endmodule

bind uerr_addr_latch ual_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flt_valid(flt_valid),
  .csr_wr   (csr_wr),
  .csr_priv (csr_priv),
  .sm_event (sm_event),
  .status_q (status_vec),
  .addr_q   (addr_flat)
);

// File: tb/uerr_addr_latch_bench.sv
module uerr_addr_latch_bench;
  localparam int NS = 2;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] flt_valid = '0;
  logic [NS*AW-1:0] flt_addr = '0;
  logic          sm_event;
  logic [1:0]    csr_addr = '0;
  logic          csr_wr = 1'b0;
  logic          csr_priv = 1'b0;
  logic [AW-1:0] csr_wdata = '0;
  logic [AW-1:0] csr_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uerr_addr_latch #(.NUM_SRC(NS), .ADDR_W(AW)) u_uerr_addr_latch (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .sm_event(sm_event), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_priv(csr_priv), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        v0;  logic [31:0] a0;
    logic        v1;  logic [31:0] a1;
    logic        wr;  logic        priv; logic [1:0] wd;
    logic [1:0]  es;  logic [31:0] ea0;  logic [31:0] ea1; logic ee;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{"R2", 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0,         1'b0, 1'b0, 2'b00, 2'b01, 32'hDEAD_BEEF, 32'h0,         1'b1},
    '{"R3", 1'b1, 32'h1234_5678, 1'b0, 32'h0,         1'b0, 1'b0, 2'b00, 2'b01, 32'hDEAD_BEEF, 32'h0,         1'b0},
    '{"R8", 1'b0, 32'h0,         1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'b00, 2'b11, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1},
    '{"R6", 1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 2'b11, 2'b11, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0},
    '{"R5", 1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b1, 2'b01, 2'b10, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0},
    '{"R7", 1'b0, 32'h0,         1'b1, 32'hA5A5_0003, 1'b1, 1'b1, 2'b10, 2'b10, 32'hDEAD_BEEF, 32'hA5A5_0003, 1'b1},
    '{"R10",1'b1, 32'h8000_0000, 1'b1, 32'h0000_1111, 1'b0, 1'b0, 2'b00, 2'b11, 32'h8000_0000, 32'hA5A5_0003, 1'b1},
    '{"R5", 1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b1, 2'b11, 2'b00, 32'h8000_0000, 32'hA5A5_0003, 1'b0},
    '{"R8", 1'b1, 32'h0F0F_0F0F, 1'b1, 32'h0000_0007, 1'b0, 1'b0, 2'b00, 2'b11, 32'h0F0F_0F0F, 32'h0000_0007, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] ofs, input logic priv, output logic [31:0] val);
    csr_addr = ofs;
    csr_priv = priv;
    #1 val = csr_rdata;
  endtask

  task automatic check_state(input string tag, input logic [1:0] es,
                             input logic [31:0] ea0, input logic [31:0] ea1);
    logic [31:0] v;
    rd(2'd0, 1'b0, v); check({tag, " status"}, v, {30'b0, es});
    rd(2'd1, 1'b0, v); check({tag, " addr0"}, v, ea0);
    rd(2'd2, 1'b0, v); check({tag, " addr1"}, v, ea1);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    check("R1 event", {31'b0, sm_event}, 32'h0);
    check_state("R1", 2'b00, 32'h0, 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      flt_valid = {VECS[k].v1, VECS[k].v0};
      flt_addr  = {VECS[k].a1, VECS[k].a0};
      csr_wr    = VECS[k].wr;
      csr_priv  = VECS[k].priv;
      csr_addr  = 2'd0;
      csr_wdata = {30'b0, VECS[k].wd};
      @(posedge clk);
      @(negedge clk);
      flt_valid = '0; csr_wr = 1'b0; csr_priv = 1'b0; csr_wdata = '0;
      check($sformatf("%s vec%0d event", VECS[k].tag, k), {31'b0, sm_event}, {31'b0, VECS[k].ee});
      check_state($sformatf("%s vec%0d", VECS[k].tag, k), VECS[k].es, VECS[k].ea0, VECS[k].ea1);
    end

    // R4: the pulse drops after one cycle
    @(negedge clk);
    check("R4 pulse width", {31'b0, sm_event}, 32'h0);

    // R9: privileged write to an address offset is ignored
    @(negedge clk);
    csr_addr = 2'd1; csr_wr = 1'b1; csr_priv = 1'b1; csr_wdata = 32'h0;
    @(negedge clk);
    csr_wr = 1'b0; csr_priv = 1'b0;
    rd(2'd1, 1'b1, v); check("R9 addr0 priv read", v, 32'h0F0F_0F0F);
    rd(2'd1, 1'b0, v); check("R9 addr0 unpriv read", v, 32'h0F0F_0F0F);
    rd(2'd0, 1'b1, v); check("R9 status priv read", v, 32'h3);

    // R3: a frozen source gives no event
    @(negedge clk);
    flt_valid = 2'b11; flt_addr = {32'h5555_5555, 32'hAAAA_AAAA};
    @(negedge clk);
    flt_valid = '0;
    check("R3 no event", {31'b0, sm_event}, 32'h0);
    check_state("R3 frozen", 2'b11, 32'h0F0F_0F0F, 32'h0000_0007);

    // R1: reset returns everything to zero
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check("R1 event after reset", {31'b0, sm_event}, 32'h0);
    check_state("R1 after reset", 2'b00, 32'h0, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule